// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that answers a master as a large serial EEPROM does. It watches the bus clock and data lines through plain inputs and pulls the data line low through a single pull-down control output. The master's open-drain bus resolves that output against its own drive. The first byte of every transfer carries a fixed four-bit family code, three select bits and the read/write bit. The three select bits must equal the three strap inputs, so up to eight of these targets can share one bus. Writes carry a two-byte memory address. The high byte contributes seven bits and the low byte eight.

Data bytes of a write are collected in a 64-entry page buffer. They reach the storage array only when the master closes the write with STOP. A modelled busy interval follows, and during it the target refuses its own device address. The master therefore polls with the device byte until an acknowledge returns. Reads stream bytes from an internal pointer that steps through the whole array. A random read is made by writing the two address bytes and then issuing a repeated START with the read bit set. The array depth and the busy length are parameters. Address bits at or above the array width are ignored.

Top module: `ee_target`

## Requirements
- R1: The device byte is acknowledged only when bits 7:4 are 1010 and bits 3:1 equal `strap_i`, and no internal write is in progress. Otherwise the target pulls nothing until the next START.
- R2: After a write device byte, the next two bytes form the address {high[6:0], low[7:0]}. High bit 7 and every address bit at or above log2(DEPTH) are ignored.
- R3: Each data byte of a write is acknowledged and placed in the page buffer at the pointer's low 6 bits. Those 6 bits then increment and wrap inside the 64-byte page. A later byte landing at the same offset replaces the earlier one.
- R4: The array changes only after a STOP that ends a write carrying at least one data byte. A START seen before that STOP discards the buffered bytes.
- R5: Such a STOP makes the target busy for BUSY_CYCLES system clocks (at least 64). While busy, the device byte is not acknowledged. Once the interval ends, it is acknowledged again.
- R6: A read returns the byte at the pointer, MSB first, then increments the pointer across the whole array, wrapping from DEPTH-1 to 0. A master ACK continues the read and a master NACK ends it.
- R7: A write of the two address bytes followed by a repeated START with the read bit reads from that address. A read without address bytes starts from the pointer left by the previous transfer. After a page write, that pointer is the in-page offset following the last data byte.
- R8: After reset `sda_pull_o` is low, and it only changes while the synchronized clock line is low.
- R9: A write that carries address bytes but no data sets the pointer and starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| strap_i | input | 3 | Board strap value that the select bits must match |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge or a read 0 bit) |

## Verification
The bench goes after five corner cases.

- Page write longer than 64 bytes, starting near the page end. A design that carried into the next page, or that kept the first value at a reused offset, would read back the wrong bytes.
- Poll right after a committing STOP. This catches a design that acknowledges during busy or never leaves busy.
- Repeated START after buffered data. This catches a design that commits the abandoned bytes.
- Address-only write. This catches a design that starts a needless busy interval.
- Sequential read from the last array location. This catches a pointer that stops or strays instead of wrapping to zero.

Mismatched strap and family bits must draw no acknowledge. Randomized short page writes with readback cover the general path.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int PAGE_W = 6;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam logic [3:0] FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_MACK
  } ee_state_t;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe_q, scl_pipe_d;
  logic [DEPTH-1:0] sda_pipe_q, sda_pipe_d;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[DEPTH-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[DEPTH-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  logic scl_p, sda_p;
  assign scl_s     = scl_pipe_q[DEPTH-2];
  assign sda_s     = sda_pipe_q[DEPTH-2];
  assign scl_p     = scl_pipe_q[DEPTH-1];
  assign sda_p     = sda_pipe_q[DEPTH-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ee_page_buffer.sv
module ee_page_buffer
  import ee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] raddr,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  logic [7:0]        data_q [PAGE_N];
  logic [PAGE_N-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (clr) valid_d = '0;
    else if (we) valid_d[waddr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == PAGE_W'(g));
    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wdata;
    end
  end

  assign rdata  = data_q[raddr];
  assign rvalid = valid_q[raddr];
endmodule

// File: rtl/ee_commit.sv
module ee_commit
  import ee_pkg::*;
#(
  parameter int BUSY_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              copy_en,
  output logic [PAGE_W-1:0] idx,
  output logic              done
);
  localparam int BUSY_EFF = (BUSY_CYCLES < PAGE_N) ? PAGE_N : BUSY_CYCLES;
  localparam int CW       = $clog2(BUSY_EFF + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == CW'(BUSY_EFF - 1)) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign idx     = cnt_q[PAGE_W-1:0];
  assign copy_en = busy_q && (cnt_q < CW'(PAGE_N));
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ee_target.sv
module ee_target
  import ee_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int BUSY_CYCLES = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int GW = AW - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic              busy, copy_en, cm_done, commit_go;
  logic [PAGE_W-1:0] cm_idx;
  ee_commit #(.BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n_s), .go(commit_go), .busy(busy),
    .copy_en(copy_en), .idx(cm_idx), .done(cm_done)
  );

  logic              buf_we, buf_clr, buf_rvalid;
  logic [PAGE_W-1:0] buf_waddr;
  logic [7:0]        buf_wdata, buf_rdata;
  ee_page_buffer u_buf (
    .clk(clk), .rst_n(rst_n_s), .clr(buf_clr | cm_done), .we(buf_we),
    .waddr(buf_waddr), .wdata(buf_wdata), .raddr(cm_idx),
    .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  logic [GW-1:0] pg_q, pg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          mem_we;
  logic [7:0]    mem_rdata;
  assign mem_we = copy_en & buf_rvalid;
  ee_mem_array #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr({pg_q, cm_idx}), .wdata(buf_rdata),
    .raddr(ptr_q), .rdata(mem_rdata)
  );

  ee_state_t  st_q, st_d, nxt_q, nxt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [6:0] hi_q, hi_d;
  logic       ack_pend_q, ack_pend_d, in_ack_q, in_ack_d;
  logic       pull_q, pull_d, pend_q, pend_d, mack_q, mack_d;
  logic [7:0] rx;
  logic [14:0] full_addr;

  assign rx        = {sh_q[6:0], sda_s};
  assign full_addr = {hi_q, rx};

  always_comb begin
    st_d = st_q;  nxt_d = nxt_q;  bit_d = bit_q;  sh_d = sh_q;
    hi_d = hi_q;  ptr_d = ptr_q;  pg_d = pg_q;
    ack_pend_d = ack_pend_q;  in_ack_d = in_ack_q;
    pull_d = pull_q;  pend_d = pend_q;  mack_d = mack_q;
    buf_we = 1'b0;  buf_clr = 1'b0;  commit_go = 1'b0;
    buf_waddr = ptr_q[PAGE_W-1:0];
    buf_wdata = rx;

    if (start_det) begin
      st_d = ST_DEV;  bit_d = '0;  pull_d = 1'b0;
      ack_pend_d = 1'b0;  in_ack_d = 1'b0;
      if (!busy) begin
        buf_clr = 1'b1;  // abandoned page data is dropped
        pend_d  = 1'b0;
      end
    end else if (stop_det) begin
      st_d = ST_IDLE;  pull_d = 1'b0;
      ack_pend_d = 1'b0;  in_ack_d = 1'b0;
      if (pend_q && !busy) begin
        commit_go = 1'b1;
        pend_d    = 1'b0;
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (in_ack_q) begin
            if (scl_fall) begin
              in_ack_d = 1'b0;  pull_d = 1'b0;  bit_d = '0;  st_d = nxt_q;
              if (nxt_q == ST_RDAT) begin
                sh_d   = mem_rdata;
                pull_d = ~mem_rdata[7];
              end
            end
          end else if (ack_pend_q) begin
            if (scl_fall) begin
              ack_pend_d = 1'b0;  in_ack_d = 1'b1;  pull_d = 1'b1;
            end
          end else if (scl_rise) begin
            sh_d  = rx;
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              unique case (st_q)
                ST_DEV: begin
                  if (rx[7:4] == FAMILY && rx[3:1] == strap_i && !busy) begin
                    ack_pend_d = 1'b1;
                    nxt_d      = rx[0] ? ST_RDAT : ST_AHI;
                  end else begin
                    st_d = ST_IDLE;
                  end
                end
                ST_AHI: begin
                  hi_d = rx[6:0];  ack_pend_d = 1'b1;  nxt_d = ST_ALO;
                end
                ST_ALO: begin
                  ptr_d = full_addr[AW-1:0];
                  pg_d  = full_addr[AW-1:PAGE_W];
                  ack_pend_d = 1'b1;  nxt_d = ST_WDAT;
                end
                default: begin  // ST_WDAT
                  buf_we = 1'b1;
                  pend_d = 1'b1;
                  ptr_d  = {ptr_q[AW-1:PAGE_W], PAGE_W'(ptr_q[PAGE_W-1:0] + 1'b1)};
                  ack_pend_d = 1'b1;  nxt_d = ST_WDAT;
                end
              endcase
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              pull_d = 1'b0;  st_d = ST_MACK;  bit_d = '0;
              ptr_d  = ptr_q + 1'b1;
            end else begin
              sh_d   = {sh_q[6:0], 1'b0};
              pull_d = ~sh_q[6];
              bit_d  = bit_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_RDAT;  bit_d = '0;  sh_d = mem_rdata;
              pull_d = ~mem_rdata[7];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= ST_IDLE;  nxt_q <= ST_IDLE;  bit_q <= '0;  sh_q <= '0;
      hi_q <= '0;  ptr_q <= '0;  pg_q <= '0;
      ack_pend_q <= 1'b0;  in_ack_q <= 1'b0;  pull_q <= 1'b0;
      pend_q <= 1'b0;  mack_q <= 1'b0;
    end else begin
      st_q <= st_d;  nxt_q <= nxt_d;  bit_q <= bit_d;  sh_q <= sh_d;
      hi_q <= hi_d;  ptr_q <= ptr_d;  pg_q <= pg_d;
      ack_pend_q <= ack_pend_d;  in_ack_q <= in_ack_d;  pull_q <= pull_d;
      pend_q <= pend_d;  mack_q <= mack_d;
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/ee_target_chk.sv
module ee_target_chk #(
  parameter int BUSY_CYCLES = 300
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic busy,
  input logic sda_pull,
  input logic mem_we,
  input logic buf_we
);
  localparam int BUSY_EFF = (BUSY_CYCLES < 64) ? 64 : BUSY_CYCLES;

  int unsigned run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < BUSY_EFF));

  assert_busy_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_q != 0) |-> (run_q == BUSY_EFF));

  assert_array_write_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_no_buffer_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  assert_pull_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);
endmodule

bind ee_target ee_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .busy(busy),
  .sda_pull(sda_pull_o), .mem_we(mem_we), .buf_we(buf_we)
);

// File: tb/sim_ee_target.sv
module sim_ee_target;
  localparam int DEPTH = 1024;
  localparam int BUSY  = 300;
  localparam int Q     = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [2:0] strap;
  logic sda_pull;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  ee_target #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_pull_o(sda_pull)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [DEPTH];
  bit         ref_known [DEPTH];
  int         mptr = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  function automatic logic [7:0] dev(logic [2:0] sel, bit rd);
    return {4'b1010, sel, rd};
  endfunction

  // apply a finished page write to the reference model
  task automatic model_write(int a16, logic [7:0] d[$]);
    int base = a16 & (DEPTH - 1);
    int pg   = base & ~63;
    for (int i = 0; i < d.size(); i++) begin
      int a = pg | ((base + i) & 63);
      ref_mem[a]   = d[i];
      ref_known[a] = 1'b1;
    end
    mptr = pg | ((base + d.size()) & 63);
  endtask

  task automatic wr_txn(int a16, logic [7:0] d[$]);
    bit ack;
    i2c_start();
    wr_byte(dev(strap, 1'b0), ack); check_eq("R1", "write device ack", ack, 1);
    wr_byte(a16[15:8], ack);        check_eq("R2", "high address ack", ack, 1);
    wr_byte(a16[7:0], ack);         check_eq("R2", "low address ack", ack, 1);
    foreach (d[i]) begin
      wr_byte(d[i], ack);
      if (!ack) check_eq("R3", "data ack", ack, 1);
    end
    i2c_stop();
    if (d.size() > 0) model_write(a16, d);
    else mptr = a16 & (DEPTH - 1);
  endtask

  // poll with the device byte; returns the number of refused tries
  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int t = 0; t < 20; t++) begin
      wq();
      i2c_start();
      wr_byte(dev(strap, 1'b0), ack);
      i2c_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic read_cur(int n, string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd_byte(d, i != n - 1);
      if (ref_known[mptr]) check_eq(req, $sformatf("read at %0h", mptr), d, ref_mem[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
  endtask

  task automatic rd_rand(int a16, int n, string req);
    bit ack;
    i2c_start();
    wr_byte(dev(strap, 1'b0), ack); check_eq("R7", "dummy write ack", ack, 1);
    wr_byte(a16[15:8], ack);
    wr_byte(a16[7:0], ack);
    i2c_rstart();
    wr_byte(dev(strap, 1'b1), ack); check_eq("R7", "read device ack", ack, 1);
    mptr = a16 & (DEPTH - 1);
    read_cur(n, req);
    i2c_stop();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] d;
    int nk;
    bit ack;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    wq(2);
    check_eq("R8", "pull after reset", sda_pull, 0);

    // single byte write, poll while busy, random read back
    q = {8'h5A};
    wr_txn(16'h0123, q);
    poll(nk);
    check_eq("R5", "first poll refused", nk > 0, 1);
    check_eq("R5", "busy ends", nk < 5, 1);
    rd_rand(16'h0123, 1, "R7");

    // wrong strap, then wrong family
    i2c_start();
    wr_byte(dev(3'b100, 1'b0), ack); check_eq("R1", "strap mismatch ack", ack, 0);
    wr_byte(8'h00, ack);             check_eq("R1", "ignored rest ack", ack, 0);
    i2c_stop(); wq();
    i2c_start();
    wr_byte({4'b1011, strap, 1'b0}, ack); check_eq("R1", "family mismatch ack", ack, 0);
    i2c_stop();

    // 70-byte page write near page end, aliased high bits
    q = {};
    for (int i = 0; i < 70; i++) q.push_back(8'($urandom));
    wr_txn(16'h847C, q);
    poll(nk);
    check_eq("R5", "page poll refused", nk > 0, 1);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack); check_eq("R7", "current read ack", ack, 1);
    check_eq("R7", "pointer after page write", mptr, 16'h0042);
    read_cur(1, "R7");
    i2c_stop();
    rd_rand(16'h0040, 64, "R3");

    // array end wrap for sequential read
    q = {8'hE1, 8'hE2}; wr_txn(16'h03FE, q); poll(nk);
    q = {8'h01, 8'h02}; wr_txn(16'h0000, q); poll(nk);
    rd_rand(16'h03FE, 4, "R6");

    // repeated START abandons buffered data
    i2c_start();
    wr_byte(dev(strap, 1'b0), ack);
    wr_byte(8'h01, ack); wr_byte(8'h23, ack);
    wr_byte(8'hA5, ack); check_eq("R4", "abandoned data ack", ack, 1);
    i2c_rstart();
    wr_byte(dev(strap, 1'b0), ack);
    i2c_stop();
    poll(nk);
    check_eq("R4", "no busy after abandoned write", nk, 0);
    rd_rand(16'h0123, 1, "R4");

    // address-only write then current read
    q = {};
    wr_txn(16'h007C, q);
    poll(nk);
    check_eq("R9", "no busy after address-only write", nk, 0);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack);
    read_cur(2, "R9");
    i2c_stop();

    // randomized short page writes with readback
    for (int it = 0; it < 12; it++) begin
      int a = $urandom % DEPTH;
      int n = 1 + ($urandom % 6);
      q = {};
      for (int i = 0; i < n; i++) q.push_back(8'($urandom));
      wr_txn(a, q);
      poll(nk);
      check_eq("R5", "random poll refused", nk > 0, 1);
      rd_rand(a, n, "R3");
    end

    summary();
    $finish;
  end
endmodule